// File: doc/BRIEF.md
# Per-Block Configuration Queue

This block sits beside a block-oriented encoder's input and decides, block by block, which block length applies. Configuration words arrive on a valid/ready control stream and wait in a small first-in first-out store. When a data block begins, the oldest word is taken out. Its length stays in force until the last symbol of that block has been accepted.

The data symbols themselves pass through the encoder's datapath and not through this block. This block only watches the data handshake and drives its ready side. Back-pressure works as follows:
- The control stream sees `cfg_ready` low while the store is full.
- The data stream may run ahead of its configuration by a few symbols (`PRE_SYMS`). After that, `sym_ready` stays low until a word for the block arrives.
- A transfer happens on either stream only in a cycle where valid and ready are both high.

A configured block has a length between `MIN_LEN` and `MAX_LEN`. A length outside that range is not stored and sets a flag that only reset clears.

Top module: `blkcfg_queue`

## Requirements
- R1: Directly after reset, `cfg_ready` is 1, `sym_ready` is 1, `len_valid` is 0 and `cfg_err` is 0.
- R2: Up to `DEPTH` words can wait in the store, not counting the word already in force. While the store is full, `cfg_ready` is 0 and no word is taken. One free slot appears in the cycle after the word in force ends its block and the next word is loaded.
- R3: Words are used in arrival order, one per data block. `len_valid` is 1 and `cur_len` holds the word's length from the cycle after loading until the block's last symbol is accepted.
- R4: With no word available for the next block, at most `PRE_SYMS` symbols are accepted and then `sym_ready` stays 0. Symbols accepted this way count toward the block that the next word configures.
- R5: If the word for a block is accepted at least one cycle before that block's first symbol is offered, `sym_ready` does not go low during the block. This holds across back-to-back blocks.
- R6: A length below `MIN_LEN` or above `MAX_LEN` is discarded and sets `cfg_err`. `cfg_err` stays 1 until reset.
- R7: The length is taken from `cfg_data[SYM_W-1:0]`. The upper padding bits, up to the next multiple of 8, have no effect.
- R8: `sym_last` is 1 exactly when the symbol offered is the one that completes the configured length. After that symbol is accepted, `len_valid` is 0 in the following cycle.
- R9: A synchronous active-low reset, held at least two cycles, empties the store and clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Control word offered |
| cfg_ready | output | 1 | Store can take a word |
| cfg_data | input | CFG_W | Block length in the low SYM_W bits, padding above |
| sym_valid | input | 1 | Data symbol offered |
| sym_ready | output | 1 | Data symbol may be accepted |
| sym_last | output | 1 | Offered symbol completes the block |
| cur_len | output | SYM_W | Block length in force |
| len_valid | output | 1 | A length is in force |
| cfg_err | output | 1 | Sticky out-of-range flag |

## Verification
The bench fills the store to capacity, with one word also in force. A design that counted the loaded word as a slot, or let a write through while full, would show `cfg_ready` at the wrong time or lose an expected length. The bench offers data with no configuration present. A design with the wrong allowance would accept the wrong number of early symbols, or it would deadlock. The bench also sends out-of-range and padded words. A decoder that looked at the padding, or that stored bad words, would put a wrong length in force. Back-to-back blocks with words queued early would catch any bubble at a block boundary.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;
  function automatic int pad_to_byte(input int bits);
    return ((bits + 7) / 8) * 8;
  endfunction
endpackage

// File: rtl/blkcfg_fifo.sv
module blkcfg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [LW-1:0]    level
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL  = LW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == FULL_LVL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/blkcfg_range.sv
module blkcfg_range #(
  parameter int SYM_W   = 8,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = (1 << SYM_W) - 1
) (
  input  logic [SYM_W-1:0] len,
  output logic             in_range
);
  localparam logic [SYM_W-1:0] LO = SYM_W'(MIN_LEN);
  localparam logic [SYM_W-1:0] HI = SYM_W'(MAX_LEN);

  assign in_range = (len >= LO) && (len <= HI);
endmodule

// File: rtl/blkcfg_tracker.sv
module blkcfg_tracker #(
  parameter int SYM_W    = 8,
  parameter int PRE_SYMS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             q_empty,
  input  logic [SYM_W-1:0] head_len,
  output logic             pop,
  output logic             sym_ready,
  output logic             sym_last,
  output logic [SYM_W-1:0] cur_len,
  output logic             len_valid
);
  localparam logic [SYM_W-1:0] PRE_V = SYM_W'(PRE_SYMS);

  logic             active;
  logic [SYM_W-1:0] len_r, cnt;
  logic             take;

  assign pop       = !active && !q_empty;
  assign sym_ready = active || (cnt < PRE_V);
  assign sym_last  = active && (cnt == len_r - 1'b1);
  assign take      = sym_valid && sym_ready;
  assign cur_len   = len_r;
  assign len_valid = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      len_r  <= '0;
      cnt    <= '0;
    end else begin
      if (take) begin
        if (sym_last) begin
          cnt    <= '0;
          active <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (pop) begin
        active <= 1'b1;
        len_r  <= head_len;
      end
    end
  end
endmodule

// File: rtl/blkcfg_queue.sv
module blkcfg_queue #(
  parameter int SYM_W    = 8,
  parameter int DEPTH    = 16,
  parameter int PRE_SYMS = 2,
  parameter int MIN_LEN  = 4,
  parameter int MAX_LEN  = (1 << SYM_W) - 1,
  localparam int CFG_W   = blkcfg_pkg::pad_to_byte(SYM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             sym_valid,
  output logic             sym_ready,
  output logic             sym_last,
  output logic [SYM_W-1:0] cur_len,
  output logic             len_valid,
  output logic             cfg_err
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [SYM_W-1:0] word_len, head_len;
  logic             len_ok, cfg_take, q_push, q_pop, q_empty, q_full;
  logic [LW-1:0]    q_level;

  assign word_len  = cfg_data[SYM_W-1:0];
  assign cfg_ready = !q_full;
  assign cfg_take  = cfg_valid && cfg_ready;
  assign q_push    = cfg_take && len_ok;

  blkcfg_range #(.SYM_W(SYM_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_range (
    .len(word_len), .in_range(len_ok)
  );

  blkcfg_fifo #(.WIDTH(SYM_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(word_len), .pop(q_pop),
    .dout(head_len), .empty(q_empty), .full(q_full), .level(q_level)
  );

  blkcfg_tracker #(.SYM_W(SYM_W), .PRE_SYMS(PRE_SYMS)) u_track (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .q_empty(q_empty),
    .head_len(head_len), .pop(q_pop), .sym_ready(sym_ready),
    .sym_last(sym_last), .cur_len(cur_len), .len_valid(len_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  cfg_err <= 1'b0;
    else if (cfg_take && !len_ok) cfg_err <= 1'b1;
  end
endmodule

// File: rtl/blkcfg_queue_chk.sv
module blkcfg_queue_chk #(
  parameter int SYM_W = 8,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_ready,
  input logic             sym_valid,
  input logic             sym_ready,
  input logic             sym_last,
  input logic [SYM_W-1:0] cur_len,
  input logic             len_valid,
  input logic             cfg_err,
  input logic [LW-1:0]    q_level
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) q_level <= FULL_LVL); // R2
  AST_FULL_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n) (q_level == FULL_LVL) |-> !cfg_ready); // R2
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && !(sym_valid && sym_ready && sym_last)) |=> (len_valid && $stable(cur_len))); // R3
  AST_STALL_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n) !sym_ready |-> !len_valid); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err); // R6
  AST_LAST_ENDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready && sym_last) |=> !len_valid); // R8
  AST_LAST_NEEDS_LEN: assert property (@(posedge clk) disable iff (!rst_n) sym_last |-> len_valid); // R8
endmodule

bind blkcfg_queue blkcfg_queue_chk #(.SYM_W(SYM_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ready(cfg_ready), .sym_valid(sym_valid),
  .sym_ready(sym_ready), .sym_last(sym_last), .cur_len(cur_len),
  .len_valid(len_valid), .cfg_err(cfg_err), .q_level(q_level)
);

// File: tb/blkcfg_queue_bench.sv
module blkcfg_queue_bench;
  localparam int CLK_P = 10;
  localparam int SW = 6;
  localparam int DEP = 16;
  localparam int PRE = 2;
  localparam int LMIN = 4;
  localparam int LMAX = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 1'b0, sym_valid = 1'b0;
  logic [7:0] cfg_data = '0;
  logic cfg_ready, sym_ready, sym_last, len_valid, cfg_err;
  logic [SW-1:0] cur_len;

  int checks = 0, errors = 0;
  int exp_q[$];
  int acc_total = 0, stalls = 0, blk_cnt = 0, cur_exp = 0;
  bit got_len = 0;

  always #(CLK_P/2) clk = ~clk;

  blkcfg_queue #(.SYM_W(SW), .DEPTH(DEP), .PRE_SYMS(PRE), .MIN_LEN(LMIN), .MAX_LEN(LMAX)) u_blkcfg_queue (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_last(sym_last), .cur_len(cur_len), .len_valid(len_valid), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: samples a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (!rst_n) begin
      got_len = 0;
      blk_cnt = 0;
    end else begin
      if (len_valid && !got_len) begin
        got_len = 1;
        if (exp_q.size() == 0) begin
          chk(0, "R3 length loaded with none expected", int'(cur_len), -1);
          cur_exp = int'(cur_len);
        end else begin
          cur_exp = exp_q.pop_front();
          chk(int'(cur_len) == cur_exp, "R3 length in force", int'(cur_len), cur_exp);
        end
      end
      if (sym_valid && !sym_ready) stalls++;
      if (sym_valid && sym_ready) begin
        acc_total++;
        if (got_len) begin
          bit el;
          el = (blk_cnt == cur_exp - 1);
          chk(sym_last == el, "R8 last flag", int'(sym_last), int'(el));
          if (el) begin
            blk_cnt = 0;
            got_len = 0;
          end else blk_cnt++;
        end else begin
          chk(sym_last == 1'b0, "R8 last before configured", int'(sym_last), 0);
          blk_cnt++;
        end
      end
    end
  end

  task automatic push_cfg(input logic [7:0] word);
    int l;
    cfg_valid = 1'b1;
    cfg_data  = word;
    #(CLK_P/4);
    while (!cfg_ready) begin
      @(negedge clk);
      #(CLK_P/4);
    end
    l = int'(word[SW-1:0]);
    if (l >= LMIN && l <= LMAX) exp_q.push_back(l);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic send_syms(input int n);
    for (int i = 0; i < n; i++) begin
      sym_valid = 1'b1;
      #(CLK_P/4);
      while (!sym_ready) begin
        @(negedge clk);
        #(CLK_P/4);
      end
      @(negedge clk);
    end
    sym_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 60000);
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, a0;
    bit done;
    @(negedge clk);
    do_reset();
    #(CLK_P/4);
    chk(cfg_ready == 1'b1, "R1 cfg_ready", int'(cfg_ready), 1);
    chk(sym_ready == 1'b1, "R1 sym_ready", int'(sym_ready), 1);
    chk(len_valid == 1'b0, "R1 len_valid", int'(len_valid), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
    @(negedge clk);

    // R5: words queued ahead, back-to-back blocks never stall
    push_cfg(8'd4); push_cfg(8'd6); push_cfg(8'd5);
    s0 = stalls;
    send_syms(15);
    chk(stalls == s0, "R5 stall cycles", stalls - s0, 0);
    repeat (2) @(negedge clk);
    #(CLK_P/4);
    chk(len_valid == 1'b0, "R3 idle after blocks", int'(len_valid), 0);
    chk(exp_q.size() == 0, "R3 all words used", exp_q.size(), 0);
    @(negedge clk);

    // R7: padding bits ignored
    push_cfg(8'hC5); push_cfg(8'h86);
    send_syms(11);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R7 padded words used", exp_q.size(), 0);

    // R4: data ahead of configuration
    a0 = acc_total;
    done = 0;
    fork begin send_syms(5); done = 1; end join_none
    repeat (6) @(negedge clk);
    #(CLK_P/4);
    chk(acc_total - a0 == PRE, "R4 early symbols", acc_total - a0, PRE);
    chk(sym_ready == 1'b0, "R4 stalled", int'(sym_ready), 0);
    @(negedge clk);
    push_cfg(8'd5);
    wait (done);
    @(negedge clk);
    repeat (2) @(negedge clk);
    chk(acc_total - a0 == 5, "R4 block completed", acc_total - a0, 5);
    chk(len_valid == 1'b0, "R8 block closed", int'(len_valid), 0);

    // R6: out-of-range words dropped, flag sticky
    push_cfg(8'd3);
    #(CLK_P/4);
    chk(cfg_err == 1'b1, "R6 flag after short length", int'(cfg_err), 1);
    @(negedge clk);
    push_cfg(8'd41);
    push_cfg(8'd0);
    push_cfg(8'd7);
    send_syms(7);
    repeat (2) @(negedge clk);
    #(CLK_P/4);
    chk(cfg_err == 1'b1, "R6 flag sticky", int'(cfg_err), 1);
    chk(exp_q.size() == 0, "R6 bad words not stored", exp_q.size(), 0);
    @(negedge clk);

    // R2: capacity is DEPTH plus the word in force
    for (int i = 0; i < DEP + 1; i++) begin
      #(CLK_P/4);
      chk(cfg_ready == 1'b1, "R2 ready before full", int'(cfg_ready), 1);
      @(negedge clk);
      push_cfg(8'(4 + (i % 5)));
    end
    cfg_valid = 1'b1;
    cfg_data  = 8'd9;
    repeat (3) begin
      #(CLK_P/4);
      chk(cfg_ready == 1'b0, "R2 full holds off writes", int'(cfg_ready), 0);
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    send_syms(4);
    @(negedge clk);
    #(CLK_P/4);
    chk(cfg_ready == 1'b1, "R2 slot freed after block", int'(cfg_ready), 1);
    @(negedge clk);
    begin
      int tot = 0;
      for (int i = 1; i < DEP + 1; i++) tot += 4 + (i % 5);
      send_syms(tot);
    end
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 queued words all used", exp_q.size(), 0);

    // R9: reset empties queue and clears flag
    push_cfg(8'd5); push_cfg(8'd6);
    do_reset();
    #(CLK_P/4);
    chk(cfg_err == 1'b0, "R9 flag cleared", int'(cfg_err), 0);
    chk(len_valid == 1'b0, "R9 nothing in force", int'(len_valid), 0);
    @(negedge clk);
    a0 = acc_total;
    sym_valid = 1'b1;
    repeat (5) @(negedge clk);
    #(CLK_P/4);
    chk(acc_total - a0 == PRE, "R9 queue emptied", acc_total - a0, PRE);
    chk(len_valid == 1'b0, "R9 no stale word", int'(len_valid), 0);
    @(negedge clk);
    sym_valid = 1'b0;
    do_reset();
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule